// File: doc/BRIEF.md
# Cartridge Bank Mapping Controller

This block is the address-translation core of a cartridge for an 8-bit console. The console CPU writes to a set of eight 4-bit control registers placed in the `$5000` page. From those registers the block forms the upper address lines of a 512 kB program flash, a 32 kB work RAM and a 32 kB pattern RAM. It also drives the A10 line that picks the nametable mirroring. A write counts only on the falling edge of the CPU bus strobe while the read/write line is low. The strobe is sampled with the system clock, so a register takes its new value on the first clock edge that sees the strobe low.

The program space `$8000`–`$FFFF` is split into two 16 kB windows. Either window can hold a fixed page, or both can be paged. A wide mode maps the whole 32 kB range with one bank number. In the pattern space only the top 1 kB window `$1C00`–`$1FFF` can be switched; the other 7 kB always maps to the first seven 1 kB pages. A strap input reserves four addresses of the register page for an external expansion device, and a decode strobe is raised for those addresses.

Top module: `cart_mapper`

## Requirements
- R1: A register write happens when a clock edge sees the bus strobe `cpu_m2` low after it was high in the previous cycle, with `cpu_rw` low and `cpu_addr` = `$5000 + 8*n` (n = 0..7). That write stores `cpu_data[3:0]` into register n. Data bits 7:4 are ignored. Read cycles are ignored. Addresses with `cpu_addr[2:0]` not zero are ignored, and so are addresses outside `$5000`–`$503F`.
- R2: A synchronous reset clears all eight registers to zero. After reset `$C000`–`$FFFF` maps to program page 31 and mirroring is vertical.
- R3: Register 6 bits 1:0 select the program mode. 0: `$8000` uses bank A and `$C000` uses fixed page 31. 1: `$8000` uses fixed page 0 and `$C000` uses bank A. 2: `$8000` uses bank A and `$C000` uses bank B. 3 (wide): the 16 kB page is {reg0, `cpu_addr[14]`}.
- R4: Bank A is {reg2 bit 0, reg0}. Bank B is {reg2 bit 1, reg1}. `prg_addr` = {page, `cpu_addr[13:0]`}. `prg_sel` equals `cpu_addr[15]`.
- R5: `wram_sel` is high exactly for `$6000`–`$7FFF`, with `wram_addr` = {reg7 bits 1:0, `cpu_addr[12:0]`}.
- R6: `chr_sel` is high for `ppu_addr` below `$2000`. In `$1C00`–`$1FFF`, `chr_addr` = {reg4 bit 0, reg3, `ppu_addr[9:0]`}. At other pattern addresses, `chr_addr` = {2'b00, `ppu_addr[12:0]`}.
- R7: Register 5 bits 1:0 set the mirroring. 0: vertical, `nt_a10` = `ppu_addr[10]`. 1: horizontal, `nt_a10` = `ppu_addr[11]`. 2: single screen, `nt_a10` = 0. 3: single screen, `nt_a10` = 1.
- R8: While `exp_mode` is high, `exp_sel` is high for `$5038`–`$503B`, with `exp_idx` = `cpu_addr[1:0]`, and writes there leave register 7 unchanged. While `exp_mode` is low, `exp_sel` is low and `$5038` writes register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | CPU read/write, low for write |
| cpu_m2 | input | 1 | CPU bus strobe |
| exp_mode | input | 1 | Strap: reserve `$5038`–`$503B` for expansion ports |
| ppu_addr | input | 14 | Picture processor address bus |
| prg_addr | output | 19 | Program flash address |
| prg_sel | output | 1 | Program flash enable |
| wram_addr | output | 15 | Work RAM address |
| wram_sel | output | 1 | Work RAM enable |
| chr_addr | output | 15 | Pattern RAM address |
| chr_sel | output | 1 | Pattern RAM enable |
| nt_a10 | output | 1 | Nametable A10 select |
| exp_sel | output | 1 | Expansion port decode strobe |
| exp_idx | output | 2 | Expansion port index |

## Verification
The bench builds the block with its default widths: 5-bit program and pattern bank numbers, 2-bit work RAM pages and eight registers. These are small enough to sweep completely. Every one of the 32 program banks is walked through all four program modes, in both windows, with a different bank B in each step. All 32 pattern banks are checked against the switched window and the seven fixed pages, and every mirroring mode is checked on all four nametables. With this configuration the bank-bit concatenations, the fixed-page constants and the reserved register-7 slot can all be reached and checked against arithmetic done in the bench.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    localparam int CPU_AW         = 16;
    localparam int PPU_AW         = 14;
    localparam int NIB_W          = 4;
    localparam int NREG           = 8;
    localparam int REG_IDX_W      = $clog2(NREG);
    localparam int REG_STRIDE_LOG = 3;
    localparam int REG_TOP_LSB    = REG_STRIDE_LOG + REG_IDX_W;
    localparam logic [CPU_AW-1:0] REG_BASE = 16'h5000;

    localparam int PRG_BANK_W  = 5;
    localparam int PRG_PAGE_AW = 14;
    localparam int PRG_AW      = PRG_BANK_W + PRG_PAGE_AW;

    localparam int CHR_BANK_W  = 5;
    localparam int CHR_PAGE_AW = 10;
    localparam int CHR_AW      = CHR_BANK_W + CHR_PAGE_AW;
    localparam int CHR_SPACE_W = 13;
    localparam int CHR_SWAP_PG = 7;

    localparam int WRAM_PAGE_W  = 2;
    localparam int WRAM_PAGE_AW = 13;
    localparam int WRAM_AW      = WRAM_PAGE_W + WRAM_PAGE_AW;

    localparam int EXP_PORTS = 4;
    localparam int EXP_IDX_W = $clog2(EXP_PORTS);
    localparam logic [CPU_AW-1:0] EXP_BASE = 16'h5038;
    localparam logic [REG_IDX_W-1:0] EXP_SHADOW_REG = REG_IDX_W'(NREG - 1);

    // register slot assignment
    localparam int RS_PRG_A  = 0;
    localparam int RS_PRG_B  = 1;
    localparam int RS_PRG_HI = 2;
    localparam int RS_CHR_LO = 3;
    localparam int RS_CHR_HI = 4;
    localparam int RS_MIRROR = 5;
    localparam int RS_MODE   = 6;
    localparam int RS_WRAM   = 7;

    typedef logic [NREG-1:0][NIB_W-1:0] regbank_t;

    typedef enum logic [1:0] {
        PRG_FIX_HI = 2'd0,
        PRG_FIX_LO = 2'd1,
        PRG_BOTH   = 2'd2,
        PRG_WIDE   = 2'd3
    } prg_mode_e;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORIZ = 2'd1,
        MIR_ONE0  = 2'd2,
        MIR_ONE1  = 2'd3
    } mirror_e;

    typedef struct packed {
        prg_mode_e                prg_mode;
        logic [PRG_BANK_W-1:0]    prg_a;
        logic [PRG_BANK_W-1:0]    prg_b;
        logic [CHR_BANK_W-1:0]    chr_bank;
        logic [WRAM_PAGE_W-1:0]   wram_page;
        mirror_e                  mirror;
    } ctrl_t;

    function automatic ctrl_t decode_regs(input regbank_t r);
        ctrl_t c;
        c.prg_mode  = prg_mode_e'(r[RS_MODE][1:0]);
        c.prg_a     = {r[RS_PRG_HI][0], r[RS_PRG_A]};
        c.prg_b     = {r[RS_PRG_HI][1], r[RS_PRG_B]};
        c.chr_bank  = {r[RS_CHR_HI][0], r[RS_CHR_LO]};
        c.wram_page = r[RS_WRAM][WRAM_PAGE_W-1:0];
        c.mirror    = mirror_e'(r[RS_MIRROR][1:0]);
        return c;
    endfunction

endpackage

// File: rtl/cart_mapper_regfile.sv
module cart_mapper_regfile
    import cart_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    input  logic              exp_mode,
    output regbank_t          regs
);
    logic                 m2_q;
    logic                 strobe_fall;
    logic                 addr_hit;
    logic [REG_IDX_W-1:0] slot;
    logic                 slot_blocked;
    logic                 wr_en;

    always_ff @(posedge clk) begin
        if (rst) m2_q <= 1'b0;
        else     m2_q <= cpu_m2;
    end

    always_comb begin
        strobe_fall  = m2_q && !cpu_m2;
        slot         = cpu_addr[REG_TOP_LSB-1:REG_STRIDE_LOG];
        addr_hit     = (cpu_addr[CPU_AW-1:REG_TOP_LSB] == REG_BASE[CPU_AW-1:REG_TOP_LSB])
                    && (cpu_addr[REG_STRIDE_LOG-1:0] == '0);
        slot_blocked = exp_mode && (slot == EXP_SHADOW_REG);
        wr_en        = strobe_fall && !cpu_rw && addr_hit && !slot_blocked;
    end

    always_ff @(posedge clk) begin
        if (rst)        regs <= '0;
        else if (wr_en) regs[slot] <= cpu_data[NIB_W-1:0];
    end
endmodule

// File: rtl/cart_mapper_prg.sv
module cart_mapper_prg
    import cart_mapper_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_sel
);
    logic                  upper_half;
    logic [PRG_BANK_W-1:0] page;

    always_comb begin
        upper_half = cpu_addr[PRG_PAGE_AW];
        unique case (ctrl.prg_mode)
            PRG_FIX_HI: page = upper_half ? '1 : ctrl.prg_a;
            PRG_FIX_LO: page = upper_half ? ctrl.prg_a : '0;
            PRG_BOTH:   page = upper_half ? ctrl.prg_b : ctrl.prg_a;
            default:    page = {ctrl.prg_a[PRG_BANK_W-2:0], upper_half};
        endcase
        prg_addr = {page, cpu_addr[PRG_PAGE_AW-1:0]};
        prg_sel  = cpu_addr[CPU_AW-1];
    end
endmodule

// File: rtl/cart_mapper_aux.sv
module cart_mapper_aux
    import cart_mapper_pkg::*;
(
    input  ctrl_t                ctrl,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [PPU_AW-1:0]    ppu_addr,
    input  logic                 exp_mode,
    output logic [WRAM_AW-1:0]   wram_addr,
    output logic                 wram_sel,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_sel,
    output logic                 nt_a10,
    output logic                 exp_sel,
    output logic [EXP_IDX_W-1:0] exp_idx
);
    logic swap_win;

    always_comb begin
        wram_sel  = cpu_addr[CPU_AW-1:WRAM_PAGE_AW] == 3'b011;
        wram_addr = {ctrl.wram_page, cpu_addr[WRAM_PAGE_AW-1:0]};

        chr_sel  = !ppu_addr[CHR_SPACE_W];
        swap_win = ppu_addr[CHR_SPACE_W-1:CHR_PAGE_AW] == (CHR_SPACE_W-CHR_PAGE_AW)'(CHR_SWAP_PG);
        if (swap_win)
            chr_addr = {ctrl.chr_bank, ppu_addr[CHR_PAGE_AW-1:0]};
        else
            chr_addr = {{(CHR_AW-CHR_SPACE_W){1'b0}}, ppu_addr[CHR_SPACE_W-1:0]};

        unique case (ctrl.mirror)
            MIR_VERT:  nt_a10 = ppu_addr[10];
            MIR_HORIZ: nt_a10 = ppu_addr[11];
            MIR_ONE0:  nt_a10 = 1'b0;
            default:   nt_a10 = 1'b1;
        endcase

        exp_sel = exp_mode && (cpu_addr[CPU_AW-1:EXP_IDX_W] == EXP_BASE[CPU_AW-1:EXP_IDX_W]);
        exp_idx = cpu_addr[EXP_IDX_W-1:0];
    end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_rw,
    input  logic                 cpu_m2,
    input  logic                 exp_mode,
    input  logic [PPU_AW-1:0]    ppu_addr,
    output logic [PRG_AW-1:0]    prg_addr,
    output logic                 prg_sel,
    output logic [WRAM_AW-1:0]   wram_addr,
    output logic                 wram_sel,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_sel,
    output logic                 nt_a10,
    output logic                 exp_sel,
    output logic [EXP_IDX_W-1:0] exp_idx
);
    regbank_t regs;
    ctrl_t    ctrl;

    cart_mapper_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_rw   (cpu_rw),
        .cpu_m2   (cpu_m2),
        .exp_mode (exp_mode),
        .regs     (regs)
    );

    assign ctrl = decode_regs(regs);

    cart_mapper_prg u_prg (
        .ctrl     (ctrl),
        .cpu_addr (cpu_addr),
        .prg_addr (prg_addr),
        .prg_sel  (prg_sel)
    );

    cart_mapper_aux u_aux (
        .ctrl      (ctrl),
        .cpu_addr  (cpu_addr),
        .ppu_addr  (ppu_addr),
        .exp_mode  (exp_mode),
        .wram_addr (wram_addr),
        .wram_sel  (wram_sel),
        .chr_addr  (chr_addr),
        .chr_sel   (chr_sel),
        .nt_a10    (nt_a10),
        .exp_sel   (exp_sel),
        .exp_idx   (exp_idx)
    );
endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker
    import cart_mapper_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_m2,
    input logic              exp_mode,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              nt_a10,
    input regbank_t          regs
);
    logic m2_d;
    always_ff @(posedge clk) begin
        if (rst) m2_d <= 1'b0;
        else     m2_d <= cpu_m2;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (regs == '0)); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(m2_d && !cpu_m2 && !cpu_rw) |=> $stable(regs)); // R1

    AST_EXP_LOCK: assert property (@(posedge clk) disable iff (rst)
        (exp_mode && m2_d && !cpu_m2 && !cpu_rw && cpu_addr == EXP_BASE) |=> $stable(regs[RS_WRAM])); // R8

    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst)
        (regs[RS_MODE][1:0] == 2'd0 && cpu_addr[15:14] == 2'b11) |-> (prg_addr[PRG_AW-1:PRG_PAGE_AW] == '1)); // R3

    AST_CHR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!ppu_addr[13] && ppu_addr[12:10] != 3'd7) |-> (chr_addr[CHR_AW-1:CHR_SPACE_W] == '0)); // R6

    AST_SINGLE_SCREEN: assert property (@(posedge clk) disable iff (rst)
        regs[RS_MIRROR][1] |-> (nt_a10 == regs[RS_MIRROR][0])); // R7
endmodule

bind cart_mapper cart_mapper_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .cpu_m2   (cpu_m2),
    .exp_mode (exp_mode),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr),
    .chr_addr (chr_addr),
    .nt_a10   (nt_a10),
    .regs     (regs)
);

// File: tb/sim_cart_mapper.sv
`timescale 1ns/1ps
module sim_cart_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic        exp_mode = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [18:0] prg_addr;
    logic        prg_sel;
    logic [14:0] wram_addr;
    logic        wram_sel;
    logic [14:0] chr_addr;
    logic        chr_sel;
    logic        nt_a10;
    logic        exp_sel;
    logic [1:0]  exp_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cart_mapper u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .exp_mode(exp_mode), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr), .prg_sel(prg_sel), .wram_addr(wram_addr), .wram_sel(wram_sel),
        .chr_addr(chr_addr), .chr_sel(chr_sel), .nt_a10(nt_a10),
        .exp_sel(exp_sel), .exp_idx(exp_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_m2 = 1'b1;
        @(negedge clk);
        cpu_m2 = 1'b0;
        @(negedge clk);
        cpu_rw = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_cycle(a, d, 1'b0);
    endtask

    task automatic probe_cpu(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic probe_ppu(input logic [13:0] a);
        ppu_addr = a;
        #1;
    endtask

    function automatic logic [4:0] exp_page(input int mode, input logic [4:0] ba,
                                            input logic [4:0] bb, input logic hi);
        case (mode)
            0: return hi ? 5'd31 : ba;
            1: return hi ? ba : 5'd0;
            2: return hi ? bb : ba;
            default: return {ba[3:0], hi};
        endcase
    endfunction

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        probe_cpu(16'hC123);
        check("R2 reset top page", 32'(prg_addr), {13'd0, 5'd31, 14'h0123});
        probe_ppu(14'h2400);
        check("R2 reset vertical mirror", 32'(nt_a10), 32'd1);
        probe_ppu(14'h2800);
        check("R2 reset vertical mirror", 32'(nt_a10), 32'd0);
        probe_cpu(16'h6000);
        check("R2 reset wram page", 32'(wram_addr), 32'h0000);

        // R3 R4: all modes x all banks
        for (int m = 0; m < 4; m++) begin
            wr(16'h5030, 8'(m));
            for (int b = 0; b < 32; b++) begin
                logic [4:0] ba, bb;
                ba = 5'(b);
                bb = 5'((b * 7 + 3) % 32);
                wr(16'h5000, {4'hA, ba[3:0]});
                wr(16'h5008, {4'h5, bb[3:0]});
                wr(16'h5010, {6'd0, bb[4], ba[4]});
                probe_cpu(16'h8000 + 16'(b * 5));
                check("R3 R4 low window", 32'(prg_addr),
                      32'({exp_page(m, ba, bb, 1'b0), 14'(b * 5)}));
                probe_cpu(16'hC000 + 16'(b * 9 + 1));
                check("R3 R4 high window", 32'(prg_addr),
                      32'({exp_page(m, ba, bb, 1'b1), 14'(b * 9 + 1)}));
            end
        end
        probe_cpu(16'h7FFF);
        check("R4 prg_sel low below 8000", 32'(prg_sel), 32'd0);
        probe_cpu(16'h8000);
        check("R4 prg_sel high at 8000", 32'(prg_sel), 32'd1);

        // R5: work RAM pages
        for (int p = 0; p < 4; p++) begin
            wr(16'h5038, 8'(p));
            probe_cpu(16'h6000 + 16'(p * 1111));
            check("R5 wram addr", 32'(wram_addr), 32'(p * 8192 + p * 1111));
            check("R5 wram sel", 32'(wram_sel), 32'd1);
        end
        probe_cpu(16'h5FFF);
        check("R5 wram sel below", 32'(wram_sel), 32'd0);
        probe_cpu(16'h8000);
        check("R5 wram sel above", 32'(wram_sel), 32'd0);

        // R6: pattern banks and fixed pages
        for (int b = 0; b < 32; b++) begin
            wr(16'h5018, 8'(b % 16));
            wr(16'h5020, 8'(b / 16));
            probe_ppu(14'h1C00 + 14'(b * 31));
            check("R6 switched window", 32'(chr_addr), 32'(b * 1024 + b * 31));
            for (int k = 0; k < 7; k++) begin
                probe_ppu(14'(k * 1024 + b * 3));
                check("R6 fixed page", 32'(chr_addr), 32'(k * 1024 + b * 3));
            end
        end
        probe_ppu(14'h1FFF);
        check("R6 chr sel", 32'(chr_sel), 32'd1);
        probe_ppu(14'h2000);
        check("R6 chr sel off", 32'(chr_sel), 32'd0);

        // R7: mirroring modes on four nametables
        for (int m = 0; m < 4; m++) begin
            wr(16'h5028, 8'(m));
            for (int t = 0; t < 4; t++) begin
                logic e;
                e = (m == 0) ? t[0] : (m == 1) ? t[1] : (m == 3);
                probe_ppu(14'h2000 + 14'(t * 1024));
                check("R7 mirroring", 32'(nt_a10), 32'(e));
            end
        end

        // R1: upper data bits, misaligned, read, out of page
        wr(16'h5028, 8'hF2);
        probe_ppu(14'h2400);
        check("R1 upper data bits ignored", 32'(nt_a10), 32'd0);
        wr(16'h5029, 8'h03);
        probe_ppu(14'h2400);
        check("R1 misaligned ignored", 32'(nt_a10), 32'd0);
        bus_cycle(16'h5028, 8'h03, 1'b1);
        probe_ppu(14'h2400);
        check("R1 read ignored", 32'(nt_a10), 32'd0);
        wr(16'h4028, 8'h03);
        probe_ppu(14'h2400);
        check("R1 outside page ignored", 32'(nt_a10), 32'd0);
        wr(16'h5068, 8'h03);
        probe_ppu(14'h2400);
        check("R1 above page ignored", 32'(nt_a10), 32'd0);

        // R8: expansion mode
        wr(16'h5038, 8'h01);
        exp_mode = 1'b1;
        wr(16'h5038, 8'h02);
        probe_cpu(16'h6004);
        check("R8 reg7 locked in expansion mode", 32'(wram_addr), 32'h2004);
        probe_cpu(16'h5039);
        check("R8 exp_sel", 32'(exp_sel), 32'd1);
        check("R8 exp_idx", 32'(exp_idx), 32'd1);
        probe_cpu(16'h503B);
        check("R8 exp_idx top", 32'(exp_idx), 32'd3);
        probe_cpu(16'h503C);
        check("R8 exp_sel off above", 32'(exp_sel), 32'd0);
        probe_cpu(16'h5037);
        check("R8 exp_sel off below", 32'(exp_sel), 32'd0);
        @(negedge clk);
        exp_mode = 1'b0;
        probe_cpu(16'h5038);
        check("R8 exp_sel off when disabled", 32'(exp_sel), 32'd0);
        wr(16'h5038, 8'h02);
        probe_cpu(16'h6004);
        check("R8 reg7 written when disabled", 32'(wram_addr), 32'h4004);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule